// File: doc/BRIEF.md
# Online Core Self-Test Sequencer

This controller tests one core of a multi-core chip with a stored scan test while every other core keeps running. A start request names the core. The controller takes that core out of service one step at a time: it stalls and drains the pipeline, cuts the core off from the interconnect, saves its critical state and invalidates its L1 data cache. It then shifts a stimulus pattern into the core's scan chain, fires one capture pulse, and shifts the response back out. While shifting out, it compares the response bit by bit with an expected vector, under a care mask. Finally it restores the core's state, reconnects the core, restarts its pipeline, and reports pass or fail with a one-cycle done pulse.

The stimulus, expected and care vectors sit in an on-chip buffer that is loaded word by word through a write port. Each quiesce and restore step is a four-phase request/acknowledge handshake with the core's own logic. If an acknowledge is missing for too long, a watchdog aborts the test. The controller still runs the restore steps so that the core returns to service, and it reports a timeout.

Top module: `core_selftest_seq`

## Requirements
- R1: The buffer holds three SCAN_LEN-bit vectors chosen by `buf_bank_i`: 0 = stimulus, 1 = expected response, 2 = care mask (1 = compare this bit); code 3 writes nothing. A write with `buf_we_i` high stores `buf_wdata_i` into bits [a*WORD_W +: WORD_W] of the chosen vector, where a = `buf_addr_i`. Bit 0 of each vector is the first bit shifted.
- R2: A start accepted in idle latches `core_sel_i`. From the next cycle until the done cycle inclusive, `target_core_o` has exactly bit `core_sel` set. In idle it is all zero.
- R3: The quiesce steps run in this fixed order on `step_req_o` bits: 0 stall/drain, 1 isolate, 2 save state, 3 invalidate L1 data cache. Each is four-phase: the request stays high until its acknowledge is seen high, then drops. The next request rises only after that acknowledge has returned low. At most one request bit is high at a time.
- R4: After quiesce, `scan_en_o` is high for SCAN_LEN cycles with `scan_si_o` carrying stimulus bit i in the i-th cycle. Next comes exactly one cycle with `capture_o` high and `scan_en_o` low. Then `scan_en_o` is high for SCAN_LEN shift-out cycles.
- R5: In the i-th shift-out cycle, `scan_so_i` is compared with expected bit i when care bit i is 1. Any such mismatch makes the test fail. Bits whose care bit is 0 never affect the result.
- R6: After shift-out, the restore steps run in order on `step_req_o` bits 4 restore state, 5 reconnect, 6 restart pipeline, with the same four-phase rule.
- R7: `done_o` is high for exactly one cycle at the end of each accepted test. In that cycle `pass_o` = no unmasked mismatch and no timeout; `pass_o` and `timeout_o` are low in every other cycle.
- R8: A start request while busy (from the acceptance cycle through the done cycle) is ignored: the target core does not change and no extra done pulse occurs.
- R9: If an acknowledge edge does not come within ACK_TIMEOUT cycles of the request phase beginning (a request stays high for exactly ACK_TIMEOUT cycles), that step is abandoned. During quiesce this skips the rest of quiesce and the whole scan test and goes to restore step 4. During restore it moves to the next restore step. The done cycle then shows `timeout_o` = 1 and `pass_o` = 0.
- R10: During and after reset, with no start, `busy_o`, `target_core_o`, `step_req_o`, `scan_en_o`, `capture_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to test one core |
| core_sel_i | input | CORE_W | Index of the core to test |
| busy_o | output | 1 | A test sequence is in progress |
| target_core_o | output | NUM_CORES | One-hot selection of the core under test |
| step_req_o | output | 7 | Handshake requests, bit = step (0..6) |
| step_ack_i | input | 7 | Handshake acknowledges, same bit order |
| scan_en_o | output | 1 | Scan shift enable to the target core |
| scan_si_o | output | 1 | Serial scan data into the target core |
| capture_o | output | 1 | Single functional capture pulse |
| scan_so_i | input | 1 | Serial scan data out of the target core |
| buf_we_i | input | 1 | Buffer word write strobe |
| buf_bank_i | input | 2 | Vector select: stimulus, expected, care |
| buf_addr_i | input | WA_W | Word address within the vector |
| buf_wdata_i | input | WORD_W | Word to write |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Test passed, valid with done |
| timeout_o | output | 1 | A handshake timed out, valid with done |

## Verification
A wrong state register or step index shows up as a request bit that rises out of order or as two request bits high together. The port checks catch it on the very cycle the wrong request appears. A slip in the shift counter changes the number of `scan_en_o` cycles, or moves the capture pulse, which is visible within one scan length. A stuck fail or timeout flag only shows on `pass_o` and `timeout_o` at the done pulse. So each test ends with the scoreboard comparing the result against a verdict computed from the loaded vectors, and with checking the logged step order and shifted-in bits.

// File: rtl/cst_pkg.sv
`timescale 1ns/1ps
package cst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SHIN,
        ST_CAPT,
        ST_SHOUT,
        ST_POST,
        ST_DONE
    } cst_state_e;

    localparam int unsigned N_STEPS   = 7;
    localparam int unsigned STEP_W    = 3;
    // quiesce steps 0..3, restore steps 4..6
    localparam logic [2:0]  LAST_PRE   = 3'd3;
    localparam logic [2:0]  FIRST_POST = 3'd4;
    localparam logic [2:0]  LAST_POST  = 3'd6;

    localparam logic [1:0]  BANK_STIM = 2'd0;
    localparam logic [1:0]  BANK_EXP  = 2'd1;
    localparam logic [1:0]  BANK_CARE = 2'd2;

endpackage

// File: rtl/cst_pattern_buf.sv
`timescale 1ns/1ps
module cst_pattern_buf #(
    parameter int unsigned SCAN_LEN = 256,
    parameter int unsigned WORD_W   = 32,
    localparam int unsigned N_WORDS = SCAN_LEN / WORD_W,
    localparam int unsigned WA_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int unsigned IDX_W   = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        bank_i,
    input  logic [WA_W-1:0]   addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              stim_o,
    output logic              exp_o,
    output logic              care_o
);

    localparam int unsigned N_BANKS = 3;

    logic [N_BANKS-1:0] rd_bits;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [SCAN_LEN-1:0] vec_d, vec_q;

        always_comb begin
            vec_d = vec_q;
            if (we_i && (bank_i == 2'(b)) && (int'(addr_i) < N_WORDS)) begin
                vec_d[int'(addr_i)*WORD_W +: WORD_W] = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vec_q <= '0;
            else        vec_q <= vec_d;
        end

        assign rd_bits[b] = vec_q[rd_idx_i];
    end

    assign stim_o = rd_bits[cst_pkg::BANK_STIM];
    assign exp_o  = rd_bits[cst_pkg::BANK_EXP];
    assign care_o = rd_bits[cst_pkg::BANK_CARE];

endmodule

// File: rtl/cst_ack_timer.sv
`timescale 1ns/1ps
module cst_ack_timer #(
    parameter int unsigned LIMIT = 1024,
    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // expired on the LIMIT-th cycle of waiting in one phase
    assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                cnt_d = '0;
        else if (run_i && !expired_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/core_selftest_seq.sv
`timescale 1ns/1ps
module core_selftest_seq #(
    parameter int unsigned NUM_CORES   = 8,
    parameter int unsigned SCAN_LEN    = 256,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned ACK_TIMEOUT = 1024,
    localparam int unsigned CORE_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int unsigned N_WORDS = SCAN_LEN / WORD_W,
    localparam int unsigned WA_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int unsigned IDX_W   = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CORE_W-1:0]    core_sel_i,
    output logic                 busy_o,
    output logic [NUM_CORES-1:0] target_core_o,
    output logic [6:0]           step_req_o,
    input  logic [6:0]           step_ack_i,
    output logic                 scan_en_o,
    output logic                 scan_si_o,
    output logic                 capture_o,
    input  logic                 scan_so_i,
    input  logic                 buf_we_i,
    input  logic [1:0]           buf_bank_i,
    input  logic [WA_W-1:0]      buf_addr_i,
    input  logic [WORD_W-1:0]    buf_wdata_i,
    output logic                 done_o,
    output logic                 pass_o,
    output logic                 timeout_o
);
    import cst_pkg::*;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SCAN_LEN - 1);

    typedef struct packed {
        cst_state_e        state;
        logic [STEP_W-1:0] step;
        logic              ph_lo;   // 0: waiting ack high, 1: waiting ack low
        logic [IDX_W-1:0]  idx;
        logic              fail;
        logic              tout;
        logic [CORE_W-1:0] core;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic stim_bit, exp_bit, care_bit;
    logic tmr_clear, tmr_run, tmr_expired;
    logic ack_sel, step_fin, step_abort;

    cst_pattern_buf #(
        .SCAN_LEN (SCAN_LEN),
        .WORD_W   (WORD_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (buf_we_i),
        .bank_i   (buf_bank_i),
        .addr_i   (buf_addr_i),
        .wdata_i  (buf_wdata_i),
        .rd_idx_i (r_q.idx),
        .stim_o   (stim_bit),
        .exp_o    (exp_bit),
        .care_o   (care_bit)
    );

    cst_ack_timer #(
        .LIMIT (ACK_TIMEOUT)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .run_i     (tmr_run),
        .expired_o (tmr_expired)
    );

    assign tmr_run = (r_q.state == ST_PRE) || (r_q.state == ST_POST);

    always_comb begin
        r_d        = r_q;
        ack_sel    = step_ack_i[r_q.step];
        step_fin   = 1'b0;
        step_abort = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_PRE;
                    r_d.step  = '0;
                    r_d.ph_lo = 1'b0;
                    r_d.idx   = '0;
                    r_d.fail  = 1'b0;
                    r_d.tout  = 1'b0;
                    r_d.core  = core_sel_i;
                end
            end

            ST_PRE, ST_POST: begin
                if (!r_q.ph_lo && ack_sel)      r_d.ph_lo = 1'b1;
                else if (r_q.ph_lo && !ack_sel) step_fin  = 1'b1;
                else if (tmr_expired)           step_abort = 1'b1;

                if (step_abort) r_d.tout = 1'b1;

                if (step_abort && (r_q.state == ST_PRE)) begin
                    r_d.state = ST_POST;
                    r_d.step  = FIRST_POST;
                    r_d.ph_lo = 1'b0;
                end else if (step_fin || step_abort) begin
                    r_d.ph_lo = 1'b0;
                    if ((r_q.state == ST_PRE) && (r_q.step == LAST_PRE)) begin
                        r_d.state = ST_SHIN;
                        r_d.idx   = '0;
                    end else if ((r_q.state == ST_POST) && (r_q.step == LAST_POST)) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                    end
                end
            end

            ST_SHIN: begin
                if (r_q.idx == IDX_LAST) begin
                    r_d.state = ST_CAPT;
                    r_d.idx   = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end

            ST_CAPT: begin
                r_d.state = ST_SHOUT;
            end

            ST_SHOUT: begin
                if (care_bit && (scan_so_i != exp_bit)) r_d.fail = 1'b1;
                if (r_q.idx == IDX_LAST) begin
                    r_d.state = ST_POST;
                    r_d.step  = FIRST_POST;
                    r_d.ph_lo = 1'b0;
                    r_d.idx   = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end

            ST_DONE: begin
                r_d.state = ST_IDLE;
            end

            default: r_d.state = ST_IDLE;
        endcase

        // restart the watchdog whenever a handshake phase changes
        tmr_clear = (r_d.state != r_q.state) || (r_d.step != r_q.step) ||
                    (r_d.ph_lo != r_q.ph_lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.step  <= '0;
            r_q.ph_lo <= 1'b0;
            r_q.idx   <= '0;
            r_q.fail  <= 1'b0;
            r_q.tout  <= 1'b0;
            r_q.core  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o        = (r_q.state != ST_IDLE);
    assign target_core_o = busy_o ? (NUM_CORES'(1) << r_q.core) : '0;
    assign step_req_o    = (tmr_run && !r_q.ph_lo) ? (7'(1) << r_q.step) : '0;
    assign scan_en_o     = (r_q.state == ST_SHIN) || (r_q.state == ST_SHOUT);
    assign scan_si_o     = (r_q.state == ST_SHIN) ? stim_bit : 1'b0;
    assign capture_o     = (r_q.state == ST_CAPT);
    assign done_o        = (r_q.state == ST_DONE);
    assign pass_o        = done_o && !r_q.fail && !r_q.tout;
    assign timeout_o     = done_o && r_q.tout;

endmodule

// File: rtl/core_selftest_seq_chk.sv
`timescale 1ns/1ps
module core_selftest_seq_chk #(
    parameter int unsigned NUM_CORES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy_o,
    input logic [NUM_CORES-1:0] target_core_o,
    input logic [6:0]           step_req_o,
    input logic [6:0]           step_ack_i,
    input logic                 scan_en_o,
    input logic                 capture_o,
    input logic                 done_o,
    input logic                 pass_o,
    input logic                 timeout_o
);

    p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_req_o));

    // a raised request stays up until its own acknowledge is seen
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_req_o != 7'd0) && ((step_req_o & step_ack_i) == 7'd0) &&
         !$past(step_req_o == 7'd0)) |=> (step_req_o != 7'd0) || done_o || scan_en_o ||
         $past(step_req_o[3:0] != 4'd0));

    p_target_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $onehot(target_core_o));

    p_target_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(target_core_o)));

    p_capture_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> (!capture_o && scan_en_o));

    p_capture_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> !scan_en_o);

    p_scan_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |-> (step_req_o == 7'd0));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || timeout_o) |-> done_o);

    p_timeout_no_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !pass_o);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ((step_req_o == 7'd0) && !scan_en_o && !capture_o &&
                     (target_core_o == '0) && !done_o));

endmodule

bind core_selftest_seq core_selftest_seq_chk #(
    .NUM_CORES (NUM_CORES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_o        (busy_o),
    .target_core_o (target_core_o),
    .step_req_o    (step_req_o),
    .step_ack_i    (step_ack_i),
    .scan_en_o     (scan_en_o),
    .capture_o     (capture_o),
    .done_o        (done_o),
    .pass_o        (pass_o),
    .timeout_o     (timeout_o)
);

// File: tb/core_selftest_seq_tb.sv
`timescale 1ns/1ps
module core_selftest_seq_tb;

    localparam int NUM_CORES   = 8;
    localparam int SCAN_LEN    = 256;
    localparam int WORD_W      = 32;
    localparam int ACK_TIMEOUT = 1024;
    localparam int N_WORDS     = SCAN_LEN / WORD_W;
    localparam int WA_W        = $clog2(N_WORDS);
    localparam int CORE_W      = $clog2(NUM_CORES);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [CORE_W-1:0]    core_sel_i = '0;
    logic                 busy_o;
    logic [NUM_CORES-1:0] target_core_o;
    logic [6:0]           step_req_o;
    logic [6:0]           step_ack_i = '0;
    logic                 scan_en_o, scan_si_o, capture_o;
    logic                 scan_so_i = 1'b0;
    logic                 buf_we_i = 1'b0;
    logic [1:0]           buf_bank_i = '0;
    logic [WA_W-1:0]      buf_addr_i = '0;
    logic [WORD_W-1:0]    buf_wdata_i = '0;
    logic                 done_o, pass_o, timeout_o;

    always #2 clk = ~clk;   // 250 MHz

    core_selftest_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_sel_i(core_sel_i),
        .busy_o(busy_o), .target_core_o(target_core_o),
        .step_req_o(step_req_o), .step_ack_i(step_ack_i),
        .scan_en_o(scan_en_o), .scan_si_o(scan_si_o), .capture_o(capture_o),
        .scan_so_i(scan_so_i), .buf_we_i(buf_we_i), .buf_bank_i(buf_bank_i),
        .buf_addr_i(buf_addr_i), .buf_wdata_i(buf_wdata_i),
        .done_o(done_o), .pass_o(pass_o), .timeout_o(timeout_o)
    );

    typedef struct {
        string             name;
        logic              pass;
        logic              tout;
        logic [CORE_W-1:0] core;
        int                nseq;
        logic [6:0][2:0]   seq;
        logic              scanned;
        int                req0_len;   // -1: not checked
    } exp_t;

    exp_t sb_q[$];

    int n_tests = 0;
    int n_fail  = 0;

    logic [SCAN_LEN-1:0] pat_v, exp_v, msk_v, resp_v, si_log;
    logic [6:0] hang = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // ---------------- core-side responder ----------------
    bit cap_seen;
    int so_idx, si_idx;
    always @(negedge clk) begin
        step_ack_i <= step_req_o & ~hang;
        if (!busy_o) begin
            cap_seen = 1'b0;
            so_idx   = 0;
            si_idx   = 0;
        end else if (capture_o) begin
            cap_seen = 1'b1;
        end else if (scan_en_o) begin
            if (!cap_seen) begin
                if (si_idx < SCAN_LEN) si_log[si_idx] = scan_si_o;
                si_idx++;
            end else begin
                if (so_idx < SCAN_LEN) scan_so_i <= resp_v[so_idx];
                so_idx++;
            end
        end
    end

    // ---------------- monitor / scoreboard ----------------
    logic [6:0]      prev_req = '0;
    logic [6:0][2:0] seq_log;
    int seq_n = 0, cap_cnt = 0, sen_cnt = 0, req0_cnt = 0, tgt_err = 0, done_total = 0;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            for (int k = 0; k < 7; k++) begin
                if (step_req_o[k] && !prev_req[k]) begin
                    if (seq_n < 7) seq_log[seq_n] = 3'(k);
                    seq_n++;
                end
            end
            prev_req = step_req_o;
            if (capture_o)     cap_cnt++;
            if (scan_en_o)     sen_cnt++;
            if (step_req_o[0]) req0_cnt++;
            if (busy_o && sb_q.size() > 0 &&
                target_core_o != (NUM_CORES'(1) << sb_q[0].core)) tgt_err++;
            if (done_o) begin
                done_total++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected done pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(pass_o == e.pass, (e.pass ? "R7" : "R5"),
                          {e.name, " pass"}, pass_o, e.pass);
                    check(timeout_o == e.tout, "R9", {e.name, " timeout"}, timeout_o, e.tout);
                    check(seq_n == e.nseq, "R3", {e.name, " step count"}, seq_n, e.nseq);
                    for (int i = 0; i < e.nseq && i < 7; i++)
                        check(seq_log[i] == e.seq[i], "R6", {e.name, " step order"},
                              seq_log[i], e.seq[i]);
                    check(cap_cnt == (e.scanned ? 1 : 0), "R4", {e.name, " capture pulses"},
                          cap_cnt, e.scanned ? 1 : 0);
                    check(sen_cnt == (e.scanned ? 2*SCAN_LEN : 0), "R4",
                          {e.name, " shift cycles"}, sen_cnt, e.scanned ? 2*SCAN_LEN : 0);
                    if (e.scanned)
                        check(si_log == pat_v, "R1", {e.name, " shifted-in stimulus"},
                              longint'(si_log[63:0]), longint'(pat_v[63:0]));
                    check(tgt_err == 0, "R2", {e.name, " target core"}, tgt_err, 0);
                    if (e.req0_len >= 0)
                        check(req0_cnt == e.req0_len, "R9", {e.name, " stall req length"},
                              req0_cnt, e.req0_len);
                end
                seq_n = 0; cap_cnt = 0; sen_cnt = 0; req0_cnt = 0; tgt_err = 0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic load_bank(input logic [1:0] bank, input logic [SCAN_LEN-1:0] v);
        for (int w = 0; w < N_WORDS; w++) begin
            @(negedge clk);
            buf_we_i    = 1'b1;
            buf_bank_i  = bank;
            buf_addr_i  = WA_W'(w);
            buf_wdata_i = v[w*WORD_W +: WORD_W];
        end
        @(negedge clk);
        buf_we_i = 1'b0;
    endtask

    function automatic logic bench_verdict();
        for (int i = 0; i < SCAN_LEN; i++)
            if (msk_v[i] && (resp_v[i] != exp_v[i])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic push_item(input string name, input int core, input logic tout,
                             input logic scanned, input int req0_len);
        exp_t e;
        e.name = name;
        e.core = CORE_W'(core);
        e.tout = tout;
        e.scanned = scanned;
        e.req0_len = req0_len;
        e.pass = !tout && bench_verdict();
        if (scanned || !tout || hang[6:4] != 0) begin
            e.nseq = 7;
            for (int i = 0; i < 7; i++) e.seq[i] = 3'(i);
        end else begin
            e.nseq = 4;
            e.seq[0] = 3'd0; e.seq[1] = 3'd4; e.seq[2] = 3'd5; e.seq[3] = 3'd6;
            e.seq[4] = '0; e.seq[5] = '0; e.seq[6] = '0;
        end
        sb_q.push_back(e);
    endtask

    task automatic pulse_start(input int core);
        @(negedge clk);
        start_i    = 1'b1;
        core_sel_i = CORE_W'(core);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_test();
        wait (sb_q.size() == 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < SCAN_LEN; i++) begin
            pat_v[i] = ((i * 7 + 3) % 5) < 2;
            exp_v[i] = ((i * 11 + 1) % 3) == 0;
        end
        msk_v  = '1;
        resp_v = exp_v;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy_o == 1'b0 && target_core_o == '0, "R10", "busy/target in reset",
              {busy_o, target_core_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(step_req_o == '0 && !scan_en_o && !capture_o && !done_o, "R10",
              "outputs after reset", {step_req_o, scan_en_o, capture_o, done_o}, 0);

        // R1 load all three vectors; bank code 3 must write nothing
        load_bank(2'd0, pat_v);
        load_bank(2'd1, exp_v);
        load_bank(2'd2, msk_v);
        load_bank(2'd3, ~pat_v);

        // exact match, core 3
        push_item("match", 3, 1'b0, 1'b1, -1);
        pulse_start(3);
        finish_test();

        // mismatch only on bits whose care bit is 0 -> pass (R5)
        for (int i = 0; i < SCAN_LEN; i++) msk_v[i] = (i % 3) != 0;
        load_bank(2'd2, msk_v);
        resp_v = exp_v;
        resp_v[3] = ~resp_v[3];
        resp_v[0] = ~resp_v[0];
        push_item("masked_diff", 6, 1'b0, 1'b1, -1);
        pulse_start(6);
        finish_test();

        // unmasked mismatch on the last compared bit -> fail (R5)
        resp_v = exp_v;
        resp_v[254] = ~resp_v[254];
        push_item("last_bit_diff", 0, 1'b0, 1'b1, -1);
        pulse_start(0);
        finish_test();

        // all-care mask, mismatch on the first bit -> fail (R5)
        msk_v = '1;
        load_bank(2'd2, msk_v);
        resp_v = exp_v;
        resp_v[0] = ~resp_v[0];
        push_item("first_bit_diff", 7, 1'b0, 1'b1, -1);
        pulse_start(7);
        finish_test();

        // R8: second start while busy is ignored
        resp_v = exp_v;
        push_item("busy_start", 2, 1'b0, 1'b1, -1);
        pulse_start(2);
        repeat (100) @(negedge clk);
        pulse_start(5);
        repeat (300) @(negedge clk);
        pulse_start(1);
        finish_test();
        repeat (50) @(negedge clk);
        check(done_total == 5 && !busy_o, "R8", "done pulses after busy start",
              done_total, 5);

        // R9: stall acknowledge never arrives
        hang = 7'b000_0001;
        push_item("stall_hang", 4, 1'b1, 1'b0, ACK_TIMEOUT);
        pulse_start(4);
        finish_test();

        // R9: restart acknowledge never arrives, during restore
        hang = 7'b100_0000;
        push_item("restart_hang", 1, 1'b1, 1'b1, -1);
        pulse_start(1);
        finish_test();
        hang = '0;

        // R2/R6 after timeouts the block still runs a clean test
        push_item("recover", 5, 1'b0, 1'b1, -1);
        pulse_start(5);
        finish_test();

        check(done_total == 8, "R7", "total done pulses", done_total, 8);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule